// File: doc/BRIEF.md
# Tearing Effect Sync Detector

This block watches one tearing-effect line driven by a display panel. The panel signals both vertical sync and horizontal sync on that one line, and the block separates the two by how long each pulse lasts. It counts the horizontal lines that follow each vertical sync. When the programmed condition is met, it raises a one-cycle match pulse. A frame transfer engine uses that pulse to start its burst while the panel's scan position is safely away from the region being rewritten.

The pin is first brought into the clock domain through a short synchronizer chain. Two width-measurement channels then look at it, one for each sync type, and each channel applies its own polarity. A pulse is judged only when it ends. If it lasted at least the vertical threshold, it is a vertical sync. Otherwise, if it lasted at least the horizontal threshold, it is a horizontal sync. Anything shorter is treated as a glitch. A control unit turns these judgements into line-counter strobes and the match pulse.

Top module: `te_sync_detector`

## Requirements
- R1: After reset `matchPulse` is 0, and in line mode no match is raised until a vertical sync has been seen.
- R2: Pulse width is counted in clock ticks. A pulse that ends after at least `hsWidthCode`+1 ticks, but fewer than the vertical threshold, is a horizontal sync. Shorter pulses are ignored.
- R3: A pulse that ends after at least (`vsWidthCode`+1)×8 ticks is a vertical sync and is never also counted as a horizontal sync.
- R4: With `hsInvert`/`vsInvert` at 1, the matching channel treats a low level on `teIn` as its active pulse level. With them at 0, a high level is the active level.
- R5: The line count clears on every vertical sync and rises by one on every horizontal sync, saturating at its maximum.
- R6: With `syncMode` 2 (line mode), a match is raised on the horizontal sync that brings the line count to `targetLine`. When `targetLine` is 0, the match is raised on the vertical sync itself.
- R7: With `syncMode` 3 (frame mode), a match is raised on every vertical sync, and horizontal syncs never raise one.
- R8: With `syncMode` 0 or 1, or with `detectEnable` low, `matchPulse` stays 0 whatever the pin does.
- R9: `matchPulse` is never high for two cycles in a row. In line mode it is raised at most once between two vertical syncs.
- R10: `matchPulse` is high in the third clock cycle after the clock edge that first samples the trailing edge of a matching pulse on `teIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick of width measurement per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| teIn | input | 1 | Tearing-effect pin from the panel (asynchronous) |
| detectEnable | input | 1 | Master enable for detection |
| hsInvert | input | 1 | Horizontal-sync channel treats low as active |
| vsInvert | input | 1 | Vertical-sync channel treats low as active |
| hsWidthCode | input | 3 | Horizontal threshold, ticks minus one |
| vsWidthCode | input | 12 | Vertical threshold, 8-tick units minus one |
| syncMode | input | 2 | 0/1 off, 2 line match, 3 frame match |
| targetLine | input | 11 | Line count that triggers a match in line mode |
| matchPulse | output | 1 | One-cycle match indication |

## Verification
A width counter that restarts late or saturates early makes pulses near either threshold go to the wrong class. That shows up as a missing or extra match right after that single pulse, so the sweep walks every width across both thresholds. A line count that is off by one moves the match to the neighbouring horizontal pulse, which can be seen within one line. A stuck arming flag shows up in the first frame as either a match before any vertical sync or a second match in the same frame. An error in the pipeline depth shows up as the match arriving on the wrong cycle after the trailing edge.

// File: rtl/te_sync_pkg.sv
package te_sync_pkg;

  localparam int VS_UNIT_LOG2 = 3;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_RSVD  = 2'd1,
    MODE_LINE  = 2'd2,
    MODE_FRAME = 2'd3
  } te_mode_e;

  typedef struct packed {
    logic chanFlush;
    logic lineClear;
    logic lineInc;
  } te_cmd_t;

  typedef struct packed {
    logic hsEnd;
    logic hsWide;
    logic hsBelowVs;
    logic vsEnd;
    logic vsWide;
    logic lineNextHit;
    logic targetZero;
  } te_stat_t;

endpackage

// File: rtl/te_width_channel.sv
module te_width_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             level,
  output logic             pulseEnd,
  output logic [CNT_W-1:0] width
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic             prevLevel;

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      cnt       <= '0;
      prevLevel <= 1'b0;
    end else begin
      prevLevel <= level;
      if (level) begin
        if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
      end else begin
        cnt <= '0;
      end
    end
  end

  assign pulseEnd = prevLevel & ~level;
  assign width    = cnt;

  AST_WIDTH_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (!level) |=> (cnt == '0)); // R2

  AST_WIDTH_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    (level && !flush && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_W'(1))); // R2

endmodule

// File: rtl/te_datapath.sv
module te_datapath
  import te_sync_pkg::*;
#(
  parameter int HS_CODE_W   = 3,
  parameter int VS_CODE_W   = 12,
  parameter int LINE_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 teIn,
  input  logic                 hsInvert,
  input  logic                 vsInvert,
  input  logic [HS_CODE_W-1:0] hsWidthCode,
  input  logic [VS_CODE_W-1:0] vsWidthCode,
  input  logic [LINE_W-1:0]    targetLine,
  input  te_cmd_t              cmd,
  output te_stat_t             stat
);

  localparam int CNT_W = VS_CODE_W + VS_UNIT_LOG2 + 1;
  localparam int NUM_CHAN = 2;
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinSync;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], teIn};
  end

  assign pinSync = syncQ[SYNC_STAGES-1];

  logic [NUM_CHAN-1:0] chanInvert;
  logic [NUM_CHAN-1:0] chanEnd;
  logic [CNT_W-1:0]    chanWidth [NUM_CHAN];

  assign chanInvert = {vsInvert, hsInvert};

  for (genvar g = 0; g < NUM_CHAN; g++) begin : gen_chan
    te_width_channel #(.CNT_W(CNT_W)) i_chan (
      .clk      (clk),
      .rstN     (rstN),
      .flush    (cmd.chanFlush),
      .level    (pinSync ^ chanInvert[g]),
      .pulseEnd (chanEnd[g]),
      .width    (chanWidth[g])
    );
  end

  logic [CNT_W-1:0] hsThresh;
  logic [CNT_W-1:0] vsThresh;

  assign hsThresh = CNT_W'(hsWidthCode) + CNT_W'(1);
  assign vsThresh = (CNT_W'(vsWidthCode) + CNT_W'(1)) << VS_UNIT_LOG2;

  logic [LINE_W-1:0] lineCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                                lineCnt <= '0;
    else if (cmd.lineClear)                   lineCnt <= '0;
    else if (cmd.lineInc && lineCnt != LINE_MAX) lineCnt <= lineCnt + LINE_W'(1);
  end

  always_comb begin
    stat.hsEnd       = chanEnd[0];
    stat.hsWide      = chanWidth[0] >= hsThresh;
    stat.hsBelowVs   = chanWidth[0] < vsThresh;
    stat.vsEnd       = chanEnd[1];
    stat.vsWide      = chanWidth[1] >= vsThresh;
    stat.lineNextHit = (lineCnt != LINE_MAX) && ((lineCnt + LINE_W'(1)) == targetLine);
    stat.targetZero  = (targetLine == '0);
  end

  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    cmd.lineClear |=> (lineCnt == '0)); // R5

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.lineInc && !cmd.lineClear && lineCnt != LINE_MAX)
      |=> (lineCnt == $past(lineCnt) + LINE_W'(1))); // R5

  AST_LINE_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (lineCnt == LINE_MAX && !cmd.lineClear) |=> (lineCnt == LINE_MAX)); // R5

endmodule

// File: rtl/te_control.sv
module te_control
  import te_sync_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     detectEnable,
  input  logic [1:0] syncMode,
  input  te_stat_t stat,
  output te_cmd_t  cmd,
  output logic     matchPulse
);

  te_mode_e modeSel;
  logic     active;
  logic     vsEvent;
  logic     hsEvent;
  logic     armed;
  logic     matchNext;

  assign modeSel = te_mode_e'(syncMode);
  assign active  = detectEnable && (modeSel == MODE_LINE || modeSel == MODE_FRAME);

  assign vsEvent = active && stat.vsEnd && stat.vsWide;
  assign hsEvent = active && stat.hsEnd && stat.hsWide && stat.hsBelowVs && !vsEvent;

  always_comb begin
    cmd.chanFlush = !active;
    cmd.lineClear = vsEvent;
    cmd.lineInc   = hsEvent;
  end

  always_comb begin
    matchNext = 1'b0;
    unique case (modeSel)
      MODE_FRAME: matchNext = vsEvent;
      MODE_LINE:  matchNext = (vsEvent && stat.targetZero) ||
                              (armed && hsEvent && stat.lineNextHit);
      default:    matchNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed      <= 1'b0;
      matchPulse <= 1'b0;
    end else begin
      matchPulse <= matchNext;
      if (!active)        armed <= 1'b0;
      else if (vsEvent)   armed <= !matchNext;
      else if (matchNext) armed <= 1'b0;
    end
  end

  AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> !matchPulse); // R9

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!active) |=> !matchPulse); // R8

  AST_NO_MATCH_UNARMED: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_LINE && !armed && !stat.vsEnd) |=> !matchPulse); // R1

  AST_FRAME_NEEDS_VS: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_FRAME && !stat.vsEnd) |=> !matchPulse); // R7

endmodule

// File: rtl/te_sync_detector.sv
module te_sync_detector
  import te_sync_pkg::*;
#(
  parameter int HS_CODE_W   = 3,
  parameter int VS_CODE_W   = 12,
  parameter int LINE_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 teIn,
  input  logic                 detectEnable,
  input  logic                 hsInvert,
  input  logic                 vsInvert,
  input  logic [HS_CODE_W-1:0] hsWidthCode,
  input  logic [VS_CODE_W-1:0] vsWidthCode,
  input  logic [1:0]           syncMode,
  input  logic [LINE_W-1:0]    targetLine,
  output logic                 matchPulse
);

  te_cmd_t  cmd;
  te_stat_t stat;

  te_datapath #(
    .HS_CODE_W   (HS_CODE_W),
    .VS_CODE_W   (VS_CODE_W),
    .LINE_W      (LINE_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .teIn        (teIn),
    .hsInvert    (hsInvert),
    .vsInvert    (vsInvert),
    .hsWidthCode (hsWidthCode),
    .vsWidthCode (vsWidthCode),
    .targetLine  (targetLine),
    .cmd         (cmd),
    .stat        (stat)
  );

  te_control i_control (
    .clk          (clk),
    .rstN         (rstN),
    .detectEnable (detectEnable),
    .syncMode     (syncMode),
    .stat         (stat),
    .cmd          (cmd),
    .matchPulse   (matchPulse)
  );

endmodule

// File: tb/test_te_sync_detector.sv
module test_te_sync_detector;

  logic        clk = 1'b0;
  logic        rstN;
  logic        teIn;
  logic        detectEnable;
  logic        hsInvert;
  logic        vsInvert;
  logic [2:0]  hsWidthCode;
  logic [11:0] vsWidthCode;
  logic [1:0]  syncMode;
  logic [10:0] targetLine;
  logic        matchPulse;

  int checks = 0;
  int errors = 0;
  int matchCount = 0;
  int doubleHigh = 0;
  logic prevMatch = 1'b0;
  logic activeLvl = 1'b1;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  te_sync_detector i_te_sync_detector (
    .clk          (clk),
    .rstN         (rstN),
    .teIn         (teIn),
    .detectEnable (detectEnable),
    .hsInvert     (hsInvert),
    .vsInvert     (vsInvert),
    .hsWidthCode  (hsWidthCode),
    .vsWidthCode  (vsWidthCode),
    .syncMode     (syncMode),
    .targetLine   (targetLine),
    .matchPulse   (matchPulse)
  );

  always @(negedge clk) begin
    if (matchPulse === 1'b1) matchCount++;
    if (prevMatch === 1'b1 && matchPulse === 1'b1) doubleHigh++;
    prevMatch <= matchPulse;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int w, input int gap);
    teIn = activeLvl;
    repeat (w) @(negedge clk);
    teIn = ~activeLvl;
    repeat (gap) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int m0;
    rstN = 1'b0; teIn = 1'b0; detectEnable = 1'b1;
    hsInvert = 1'b0; vsInvert = 1'b0;
    hsWidthCode = 3'd1; vsWidthCode = 12'd0;
    syncMode = 2'd2; targetLine = 11'd1;
    repeat (5) @(negedge clk);
    check(matchPulse == 1'b0, "R1 reset", int'(matchPulse), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: horizontal pulse before any vertical sync must not match
    m0 = matchCount;
    pulse(3, 10);
    check(matchCount == m0, "R1 no match before first vsync", matchCount - m0, 0);

    // R2/R3/R4: width classification sweep across both thresholds
    for (int pol = 0; pol < 2; pol++) begin
      hsInvert = pol[0]; vsInvert = pol[0];
      activeLvl = ~pol[0];
      teIn = ~activeLvl;
      repeat (6) @(negedge clk);
      for (int hs = 0; hs < 8; hs++) begin
        for (int vs = 0; vs < 3; vs++) begin
          int hsT;
          int vsT;
          hsT = hs + 1;
          vsT = (vs + 1) * 8;
          hsWidthCode = 3'(hs); vsWidthCode = 12'(vs);
          for (int w = 1; w <= vsT + 2; w++) begin
            int exp;
            pulse(vsT + 4, 6);
            m0 = matchCount;
            pulse(w, 8);
            exp = (w >= hsT && w < vsT) ? 1 : 0;
            if (pol == 1)
              check(matchCount - m0 == exp, "R4 inverted polarity class", matchCount - m0, exp);
            else if (w >= vsT)
              check(matchCount - m0 == exp, "R3 vsync not hsync", matchCount - m0, exp);
            else
              check(matchCount - m0 == exp, "R2 hsync threshold", matchCount - m0, exp);
          end
        end
      end
    end

    hsInvert = 1'b0; vsInvert = 1'b0; activeLvl = 1'b1; teIn = 1'b0;
    hsWidthCode = 3'd1; vsWidthCode = 12'd0;
    repeat (6) @(negedge clk);

    // R5/R6/R9: line counting and target match, once per frame
    for (int t = 0; t < 7; t++) begin
      int frameStart;
      targetLine = 11'(t);
      frameStart = matchCount;
      m0 = matchCount;
      pulse(12, 6);
      check(matchCount - m0 == (t == 0 ? 1 : 0), "R6 target zero on vsync",
            matchCount - m0, (t == 0 ? 1 : 0));
      for (int k = 1; k <= 8; k++) begin
        m0 = matchCount;
        pulse(3, 6);
        check(matchCount - m0 == (k == t ? 1 : 0), "R5 line count match",
              matchCount - m0, (k == t ? 1 : 0));
      end
      check(matchCount - frameStart == 1, "R9 once per frame", matchCount - frameStart, 1);
    end

    // R7: frame mode matches every vsync, never hsync
    syncMode = 2'd3; targetLine = 11'd2;
    for (int f = 0; f < 3; f++) begin
      m0 = matchCount;
      pulse(12, 6);
      check(matchCount - m0 == 1, "R7 frame mode vsync", matchCount - m0, 1);
      m0 = matchCount;
      pulse(3, 6); pulse(3, 6); pulse(3, 6);
      check(matchCount - m0 == 0, "R7 frame mode ignores hsync", matchCount - m0, 0);
    end

    // R10: latency from trailing edge
    begin
      int seen;
      seen = 0;
      teIn = 1'b1;
      repeat (12) @(negedge clk);
      teIn = 1'b0;
      for (int n = 1; n <= 6; n++) begin
        @(negedge clk);
        if (matchPulse && seen == 0) seen = n;
      end
      check(seen == 3, "R10 match latency", seen, 3);
    end

    // R8: disabled modes and enable gate
    for (int md = 0; md < 4; md++) begin
      for (int en = 0; en < 2; en++) begin
        if (md >= 2 && en == 1) continue;
        syncMode = 2'(md); detectEnable = en[0]; targetLine = 11'd0;
        repeat (4) @(negedge clk);
        m0 = matchCount;
        pulse(12, 6); pulse(3, 6); pulse(3, 6);
        check(matchCount - m0 == 0, "R8 detection off", matchCount - m0, 0);
      end
    end

    check(doubleHigh == 0, "R9 single-cycle pulse", doubleHigh, 0);
    finish_run();
  end

endmodule